// File: doc/BRIEF.md
# Power-Management Register File with Interrupt Controller

This block is the register side of a power-management companion device. It sits behind a serial-bus slave that has already turned bus frames into parallel register accesses. It decodes a 32-entry index space of 16-bit words. It keeps pending and mask state for interrupts and drives one active-high interrupt line. It also reports an identification word whose variant bit is taken from a strap input.

Software selects an ADC channel by writing the channel number into the ADC word. It then reads back a fixed, preloaded conversion result for that channel. That write also raises the "sample done" interrupt. A power-key event raises the key interrupt and updates a key bit in the status word. An ADC-complete event sets a flag in the sample-control word, and software clears that flag by writing ones. A zero written to the watchdog word asks the system to shut down, but only while the enabling bit in the first common-control word is set.

Register indices that belong to functions not built here read as zero and ignore writes. Indices that belong to no function at all also read as zero, and they latch an error flag that stays set until reset.

Top module: `pmic_regfile`

## Requirements
- R1: Index 0 is read-only. It reads 0x0215, and bit 7 of the read value equals `variant_sel`. Writes to index 0 change nothing.
- R2: A write to index 1 XORs the written data into the pending word. Reading index 1 returns the pending word. Pending bits are 0 after reset.
- R3: Index 2 is the mask word. It resets to 0xFFFF and can be read and written.
- R4: `irq` is high exactly when some pending bit has its mask bit at 0.
- R5: A write to index 8 takes the channel from data bits 13..10 and sets pending bit 8. Reading index 8 returns (channel << 10) OR the preset 10-bit result for that channel. Preset results by channel: 1→0x3C2, 2→0x0FC, 3→0x165, 4→0x07B, 5→0x3FF, 6→0x011, 7→0x011, 8→0x250, 10→0x002, 11→0x011, 12→0x3D0, 13→0x330. Every other channel reads 0.
- R6: Index 9 is the sample-control word and resets to 0. A one-cycle `adc_done` pulse sets bit 0. A write clears each bit that is 1 in the written data. Zero bits in the written data leave the word unchanged.
- R7: Index 0x16 is the status word and resets to 0x0020. A one-cycle `key_evt` pulse sets pending bit 0. The same pulse sets status bit 5 to the inverse of `key_level`, where `key_level` is 1 while the key is pressed.
- R8: A write of 0x0000 to index 0x17 while bit 1 of index 0x0D is 1 makes `shutdown_req` high for exactly the one cycle after that write. Any other write to index 0x17 leaves `shutdown_req` low.
- R9: Index 6 resets to 0x0001. Indices 0x0D and 0x0E reset to 0. All three read back the last value written.
- R10: Indices 3, 4, 5, 0x0A to 0x0C, 0x0F to 0x11, 0x17 and 0x18 to 0x1F read as 0. Writes to them store nothing, and accesses to them leave `acc_err` unchanged.
- R11: A read or write of index 7 or 0x12 to 0x15 returns 0 and sets `acc_err`. `acc_err` then stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_en | input | 1 | Register access strobe, one cycle per access |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_idx | input | 5 | Register index |
| acc_wdata | input | 16 | Write data |
| acc_rdata | output | 16 | Read data for `acc_idx`, combinational |
| key_evt | input | 1 | Power-key change event pulse |
| key_level | input | 1 | Power-key state, 1 = pressed |
| adc_done | input | 1 | ADC-complete event pulse |
| variant_sel | input | 1 | Device variant strap |
| irq | output | 1 | Active-high interrupt |
| shutdown_req | output | 1 | One-cycle shutdown request |
| acc_err | output | 1 | Sticky unmapped-access flag |

## Verification
The bench uses the default parameters: a 5-bit index, 16-bit words, a 4-bit channel field above a 10-bit result, and the preset ADC table turned on. With these values every index can be reached, including every unmapped hole. The channel field reaches every table entry, so the readback checks compare real table values and not zeros. Bit 8 of the pending word, the ADC interrupt, is present, so the toggle acknowledge of that interrupt can be checked as well.

// File: rtl/pmic_pkg.sv
package pmic_pkg;

   localparam int IDX_ID    = 0;
   localparam int IDX_PEND  = 1;
   localparam int IDX_MASK  = 2;
   localparam int IDX_CAL   = 6;
   localparam int IDX_ADC   = 8;
   localparam int IDX_SAMP  = 9;
   localparam int IDX_CC1   = 13;
   localparam int IDX_CC2   = 14;
   localparam int IDX_STAT  = 22;
   localparam int IDX_WDOG  = 23;

   localparam int PEND_BIT_KEY  = 0;
   localparam int PEND_BIT_ADC  = 8;
   localparam int STAT_BIT_KEY  = 5;
   localparam int CC1_BIT_WDOG  = 1;

   typedef enum logic [1:0] {
      ACC_LIVE = 2'd0,
      ACC_ZERO = 2'd1,
      ACC_BAD  = 2'd2
   } acc_kind_e;

   typedef struct packed {
      logic pend;
      logic mask;
      logic cal;
      logic adc;
      logic samp;
      logic cc1;
      logic cc2;
      logic wdog;
   } wr_strobe_t;

   function automatic acc_kind_e classify(input int idx);
      acc_kind_e k;
      if (idx > 31)
         k = ACC_BAD;
      else begin
         case (idx)
            IDX_ID, IDX_PEND, IDX_MASK, IDX_CAL, IDX_ADC, IDX_SAMP,
            IDX_CC1, IDX_CC2, IDX_STAT, IDX_WDOG: k = ACC_LIVE;
            7, 18, 19, 20, 21:                    k = ACC_BAD;
            default:                              k = ACC_ZERO;
         endcase
      end
      return k;
   endfunction

   function automatic int adc_preset(input int ch);
      int r;
      case (ch)
         1:       r = 'h3C2;
         2:       r = 'h0FC;
         3:       r = 'h165;
         4:       r = 123;
         5:       r = 1023;
         6, 7:    r = 'h011;
         8:       r = 'h250;
         10:      r = 2;
         11:      r = 'h011;
         12:      r = 'h3D0;
         13:      r = 'h330;
         default: r = 0;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/pmic_decode.sv
module pmic_decode
   import pmic_pkg::*;
#(
   parameter int ADDR_W = 5
) (
   input  logic              acc_en,
   input  logic              acc_wr,
   input  logic [ADDR_W-1:0] acc_idx,
   output wr_strobe_t        wr_stb,
   output logic              bad_acc
);

   int        idx_int;
   acc_kind_e kind;
   logic      do_wr;

   assign idx_int = int'(acc_idx);
   assign kind    = classify(idx_int);
   assign do_wr   = acc_en && acc_wr;
   assign bad_acc = acc_en && (kind == ACC_BAD);

   always_comb begin
      wr_stb      = '0;
      wr_stb.pend = do_wr && (idx_int == IDX_PEND);
      wr_stb.mask = do_wr && (idx_int == IDX_MASK);
      wr_stb.cal  = do_wr && (idx_int == IDX_CAL);
      wr_stb.adc  = do_wr && (idx_int == IDX_ADC);
      wr_stb.samp = do_wr && (idx_int == IDX_SAMP);
      wr_stb.cc1  = do_wr && (idx_int == IDX_CC1);
      wr_stb.cc2  = do_wr && (idx_int == IDX_CC2);
      wr_stb.wdog = do_wr && (idx_int == IDX_WDOG);
   end

endmodule

// File: rtl/pmic_irq_ctrl.sv
module pmic_irq_ctrl #(
   parameter int          IRQ_W    = 16,
   parameter logic [IRQ_W-1:0] MASK_RST = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_pend,
   input  logic             wr_mask,
   input  logic [IRQ_W-1:0] wdata,
   input  logic [IRQ_W-1:0] set_bits,
   output logic [IRQ_W-1:0] pend_q,
   output logic [IRQ_W-1:0] mask_q,
   output logic             irq
);

   logic [IRQ_W-1:0] pend_toggled;

   // toggle first, then new events; an event in the same cycle wins
   assign pend_toggled = wr_pend ? (pend_q ^ wdata) : pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
         mask_q <= MASK_RST;
      end else begin
         pend_q <= pend_toggled | set_bits;
         if (wr_mask)
            mask_q <= wdata;
      end
   end

   assign irq = |(pend_q & ~mask_q);

endmodule

// File: rtl/pmic_adc_unit.sv
module pmic_adc_unit
   import pmic_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int CHAN_W   = 4,
   parameter int RES_W    = 10,
   parameter bit TABLE_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_adc,
   input  logic              wr_samp,
   input  logic [DATA_W-1:0] wdata,
   input  logic              done_evt,
   output logic [DATA_W-1:0] adc_word,
   output logic [DATA_W-1:0] samp_word
);

   logic [CHAN_W-1:0] chan_q;
   logic [RES_W-1:0]  result;
   logic [DATA_W-1:0] samp_q;
   logic [DATA_W-1:0] samp_kept;
   logic [DATA_W-1:0] done_bit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         chan_q <= '0;
      else if (wr_adc)
         chan_q <= wdata[RES_W +: CHAN_W];
   end

   generate
      if (TABLE_EN) begin : g_table
         always_comb result = RES_W'(adc_preset(int'(chan_q)));
      end else begin : g_no_table
         always_comb result = '0;
      end
   endgenerate

   assign adc_word = (DATA_W'(chan_q) << RES_W) | DATA_W'(result);

   assign samp_kept = wr_samp ? (samp_q & ~wdata) : samp_q;
   assign done_bit  = {{(DATA_W-1){1'b0}}, done_evt};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         samp_q <= '0;
      else
         samp_q <= samp_kept | done_bit;
   end

   assign samp_word = samp_q;

endmodule

// File: rtl/pmic_ctrl_regs.sv
module pmic_ctrl_regs
   import pmic_pkg::*;
#(
   parameter int               DATA_W   = 16,
   parameter logic [DATA_W-1:0] CAL_RST  = 16'h0001,
   parameter logic [DATA_W-1:0] STAT_RST = 16'h0020
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_cal,
   input  logic              wr_cc1,
   input  logic              wr_cc2,
   input  logic              wr_wdog,
   input  logic [DATA_W-1:0] wdata,
   input  logic              key_evt,
   input  logic              key_level,
   output logic [DATA_W-1:0] cal_q,
   output logic [DATA_W-1:0] cc1_q,
   output logic [DATA_W-1:0] cc2_q,
   output logic [DATA_W-1:0] stat_q,
   output logic              shut_q
);

   logic shut_arm;

   assign shut_arm = wr_wdog && (wdata == '0) && cc1_q[CC1_BIT_WDOG];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cal_q  <= CAL_RST;
         cc1_q  <= '0;
         cc2_q  <= '0;
         stat_q <= STAT_RST;
         shut_q <= 1'b0;
      end else begin
         if (wr_cal) cal_q <= wdata;
         if (wr_cc1) cc1_q <= wdata;
         if (wr_cc2) cc2_q <= wdata;
         if (key_evt) stat_q[STAT_BIT_KEY] <= !key_level;
         shut_q <= shut_arm;
      end
   end

endmodule

// File: rtl/pmic_regfile.sv
module pmic_regfile
   import pmic_pkg::*;
#(
   parameter int ADDR_W       = 5,
   parameter int DATA_W       = 16,
   parameter int CHAN_W       = 4,
   parameter int RES_W        = 10,
   parameter logic [15:0] ASIC_ID = 16'h0215,
   parameter int VARIANT_BIT  = 7,
   parameter logic [15:0] MASK_RST = 16'hFFFF,
   parameter logic [15:0] CAL_RST  = 16'h0001,
   parameter logic [15:0] STAT_RST = 16'h0020,
   parameter bit ADC_TABLE_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_en,
   input  logic              acc_wr,
   input  logic [ADDR_W-1:0] acc_idx,
   input  logic [DATA_W-1:0] acc_wdata,
   output logic [DATA_W-1:0] acc_rdata,
   input  logic              key_evt,
   input  logic              key_level,
   input  logic              adc_done,
   input  logic              variant_sel,
   output logic              irq,
   output logic              shutdown_req,
   output logic              acc_err
);

   localparam logic [DATA_W-1:0] ID_BASE = DATA_W'(ASIC_ID);

   generate
      if (DATA_W < CHAN_W + RES_W) begin : g_bad_adc_fit
         $error("pmic_regfile: channel and result do not fit in a word");
      end
      if (ADDR_W < 5) begin : g_bad_addr
         $error("pmic_regfile: index width must cover 32 entries");
      end
      if (VARIANT_BIT >= DATA_W || PEND_BIT_ADC >= DATA_W
          || STAT_BIT_KEY >= DATA_W) begin : g_bad_bits
         $error("pmic_regfile: fixed bit positions exceed the data width");
      end
   endgenerate

   wr_strobe_t        wr_stb;
   logic              bad_acc;
   logic [DATA_W-1:0] set_bits;
   logic [DATA_W-1:0] pend_w;
   logic [DATA_W-1:0] mask_w;
   logic [DATA_W-1:0] adc_word;
   logic [DATA_W-1:0] samp_word;
   logic [DATA_W-1:0] cal_w;
   logic [DATA_W-1:0] cc1_w;
   logic [DATA_W-1:0] cc2_w;
   logic [DATA_W-1:0] stat_w;
   logic [DATA_W-1:0] id_word;
   logic              err_q;
   int                idx_int;

   pmic_decode #(.ADDR_W(ADDR_W)) u_decode (
      .acc_en  (acc_en),
      .acc_wr  (acc_wr),
      .acc_idx (acc_idx),
      .wr_stb  (wr_stb),
      .bad_acc (bad_acc)
   );

   always_comb begin
      set_bits               = '0;
      set_bits[PEND_BIT_KEY] = key_evt;
      set_bits[PEND_BIT_ADC] = wr_stb.adc;
   end

   pmic_irq_ctrl #(.IRQ_W(DATA_W), .MASK_RST(DATA_W'(MASK_RST))) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_pend  (wr_stb.pend),
      .wr_mask  (wr_stb.mask),
      .wdata    (acc_wdata),
      .set_bits (set_bits),
      .pend_q   (pend_w),
      .mask_q   (mask_w),
      .irq      (irq)
   );

   pmic_adc_unit #(
      .DATA_W   (DATA_W),
      .CHAN_W   (CHAN_W),
      .RES_W    (RES_W),
      .TABLE_EN (ADC_TABLE_EN)
   ) u_adc (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_adc    (wr_stb.adc),
      .wr_samp   (wr_stb.samp),
      .wdata     (acc_wdata),
      .done_evt  (adc_done),
      .adc_word  (adc_word),
      .samp_word (samp_word)
   );

   pmic_ctrl_regs #(
      .DATA_W   (DATA_W),
      .CAL_RST  (DATA_W'(CAL_RST)),
      .STAT_RST (DATA_W'(STAT_RST))
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_cal    (wr_stb.cal),
      .wr_cc1    (wr_stb.cc1),
      .wr_cc2    (wr_stb.cc2),
      .wr_wdog   (wr_stb.wdog),
      .wdata     (acc_wdata),
      .key_evt   (key_evt),
      .key_level (key_level),
      .cal_q     (cal_w),
      .cc1_q     (cc1_w),
      .cc2_q     (cc2_w),
      .stat_q    (stat_w),
      .shut_q    (shutdown_req)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         err_q <= 1'b0;
      else if (bad_acc)
         err_q <= 1'b1;
   end
   assign acc_err = err_q;

   assign id_word = ID_BASE | (DATA_W'(variant_sel) << VARIANT_BIT);
   assign idx_int = int'(acc_idx);

   always_comb begin
      case (idx_int)
         IDX_ID:   acc_rdata = id_word;
         IDX_PEND: acc_rdata = pend_w;
         IDX_MASK: acc_rdata = mask_w;
         IDX_CAL:  acc_rdata = cal_w;
         IDX_ADC:  acc_rdata = adc_word;
         IDX_SAMP: acc_rdata = samp_word;
         IDX_CC1:  acc_rdata = cc1_w;
         IDX_CC2:  acc_rdata = cc2_w;
         IDX_STAT: acc_rdata = stat_w;
         default:  acc_rdata = '0;
      endcase
   end

endmodule

// File: rtl/pmic_regfile_chk.sv
module pmic_regfile_chk
   import pmic_pkg::*;
#(
   parameter int ADDR_W = 5,
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              acc_en,
   input logic              acc_wr,
   input logic [ADDR_W-1:0] acc_idx,
   input logic [DATA_W-1:0] acc_wdata,
   input logic              key_evt,
   input logic              irq,
   input logic              shutdown_req,
   input logic              acc_err,
   input logic [DATA_W-1:0] pend_q,
   input logic [DATA_W-1:0] mask_q
);

   logic wr_pend_acc, wr_mask_acc, wr_adc_acc, wr_wdog_zero;

   assign wr_pend_acc  = acc_en && acc_wr && (acc_idx == ADDR_W'(IDX_PEND));
   assign wr_mask_acc  = acc_en && acc_wr && (acc_idx == ADDR_W'(IDX_MASK));
   assign wr_adc_acc   = acc_en && acc_wr && (acc_idx == ADDR_W'(IDX_ADC));
   assign wr_wdog_zero = acc_en && acc_wr && (acc_idx == ADDR_W'(IDX_WDOG))
                         && (acc_wdata == '0);

   a_r2_toggle_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_pend_acc && !key_evt) |=> (pend_q == $past(pend_q ^ acc_wdata)));

   a_r3_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
      wr_mask_acc |=> (mask_q == $past(acc_wdata)));

   a_r4_quiet_when_masked: assert property (@(posedge clk) disable iff (!rst_n)
      ((pend_q & ~mask_q) == '0) |-> !irq);

   a_r4_fires_when_open: assert property (@(posedge clk) disable iff (!rst_n)
      ((pend_q & ~mask_q) != '0) |-> irq);

   a_r5_adc_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
      wr_adc_acc |=> pend_q[PEND_BIT_ADC]);

   a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      shutdown_req |=> !shutdown_req);

   a_r8_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
      shutdown_req |-> $past(wr_wdog_zero));

   a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      acc_err |=> acc_err);

endmodule

bind pmic_regfile pmic_regfile_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .acc_en       (acc_en),
   .acc_wr       (acc_wr),
   .acc_idx      (acc_idx),
   .acc_wdata    (acc_wdata),
   .key_evt      (key_evt),
   .irq          (irq),
   .shutdown_req (shutdown_req),
   .acc_err      (acc_err),
   .pend_q       (pend_w),
   .mask_q       (mask_w)
);

// File: tb/pmic_regfile_bench.sv
`timescale 1ns/1ps
module pmic_regfile_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_en = 1'b0;
   logic        acc_wr = 1'b0;
   logic [4:0]  acc_idx = '0;
   logic [15:0] acc_wdata = '0;
   logic [15:0] acc_rdata;
   logic        key_evt = 1'b0;
   logic        key_level = 1'b0;
   logic        adc_done = 1'b0;
   logic        variant_sel = 1'b0;
   logic        irq;
   logic        shutdown_req;
   logic        acc_err;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   pmic_regfile u_pmic_regfile (
      .clk          (clk),
      .rst_n        (rst_n),
      .acc_en       (acc_en),
      .acc_wr       (acc_wr),
      .acc_idx      (acc_idx),
      .acc_wdata    (acc_wdata),
      .acc_rdata    (acc_rdata),
      .key_evt      (key_evt),
      .key_level    (key_level),
      .adc_done     (adc_done),
      .variant_sel  (variant_sel),
      .irq          (irq),
      .shutdown_req (shutdown_req),
      .acc_err      (acc_err)
   );

   // {req[3:0], wr, idx[4:0], wdata[15:0], expected read[15:0]}
   localparam int NV = 41;
   localparam logic [41:0] VEC [NV] = '{
      {4'd1,  1'b0, 5'h00, 16'h0000, 16'h0215},  // R1 identity
      {4'd3,  1'b0, 5'h02, 16'h0000, 16'hFFFF},  // R3 mask reset
      {4'd9,  1'b0, 5'h06, 16'h0000, 16'h0001},  // R9 cal reset
      {4'd7,  1'b0, 5'h16, 16'h0000, 16'h0020},  // R7 status reset
      {4'd6,  1'b0, 5'h09, 16'h0000, 16'h0000},  // R6 sample reset
      {4'd2,  1'b0, 5'h01, 16'h0000, 16'h0000},  // R2 pending reset
      {4'd9,  1'b1, 5'h06, 16'hABCD, 16'h0000},
      {4'd9,  1'b0, 5'h06, 16'h0000, 16'hABCD},
      {4'd9,  1'b1, 5'h0D, 16'h0002, 16'h0000},
      {4'd9,  1'b0, 5'h0D, 16'h0000, 16'h0002},
      {4'd9,  1'b1, 5'h0E, 16'h1234, 16'h0000},
      {4'd9,  1'b0, 5'h0E, 16'h0000, 16'h1234},
      {4'd5,  1'b1, 5'h08, 16'h2000, 16'h0000},  // R5 channel 8
      {4'd5,  1'b0, 5'h08, 16'h0000, 16'h2250},
      {4'd5,  1'b0, 5'h01, 16'h0000, 16'h0100},  // R5 sample-done pending
      {4'd2,  1'b1, 5'h01, 16'h0100, 16'h0000},
      {4'd2,  1'b0, 5'h01, 16'h0000, 16'h0000},
      {4'd5,  1'b1, 5'h08, 16'h0400, 16'h0000},  // channel 1
      {4'd5,  1'b0, 5'h08, 16'h0000, 16'h07C2},
      {4'd5,  1'b1, 5'h08, 16'h2C00, 16'h0000},  // channel 11
      {4'd5,  1'b0, 5'h08, 16'h0000, 16'h2C11},
      {4'd5,  1'b1, 5'h08, 16'h3400, 16'h0000},  // channel 13
      {4'd5,  1'b0, 5'h08, 16'h0000, 16'h3730},
      {4'd5,  1'b1, 5'h08, 16'h0000, 16'h0000},  // channel 0
      {4'd5,  1'b0, 5'h08, 16'h0000, 16'h0000},
      {4'd2,  1'b1, 5'h01, 16'h0100, 16'h0000},
      {4'd2,  1'b0, 5'h01, 16'h0000, 16'h0000},
      {4'd10, 1'b1, 5'h1A, 16'hFFFF, 16'h0000},  // R10 audio slot
      {4'd10, 1'b0, 5'h1A, 16'h0000, 16'h0000},
      {4'd10, 1'b1, 5'h04, 16'h1111, 16'h0000},  // R10 time slot
      {4'd10, 1'b0, 5'h04, 16'h0000, 16'h0000},
      {4'd10, 1'b0, 5'h17, 16'h0000, 16'h0000},  // R10 watchdog reads 0
      {4'd1,  1'b1, 5'h00, 16'hFFFF, 16'h0000},
      {4'd1,  1'b0, 5'h00, 16'h0000, 16'h0215},  // R1 write ignored
      {4'd2,  1'b1, 5'h01, 16'h0003, 16'h0000},
      {4'd2,  1'b0, 5'h01, 16'h0000, 16'h0003},
      {4'd2,  1'b1, 5'h01, 16'h0001, 16'h0000},
      {4'd2,  1'b0, 5'h01, 16'h0000, 16'h0002},
      {4'd2,  1'b1, 5'h01, 16'h0002, 16'h0000},
      {4'd2,  1'b0, 5'h01, 16'h0000, 16'h0000},
      {4'd9,  1'b0, 5'h0D, 16'h0000, 16'h0002}
   };

   task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic do_write(input logic [4:0] idx, input logic [15:0] d);
      @(negedge clk);
      acc_en = 1'b1; acc_wr = 1'b1; acc_idx = idx; acc_wdata = d;
      @(posedge clk);
      #1 acc_en = 1'b0; acc_wr = 1'b0;
   endtask

   task automatic do_read(input logic [4:0] idx, output logic [15:0] d);
      @(negedge clk);
      acc_en = 1'b1; acc_wr = 1'b0; acc_idx = idx;
      #2 d = acc_rdata;
      @(posedge clk);
      #1 acc_en = 1'b0;
   endtask

   task automatic read_check(input string tag, input logic [4:0] idx, input logic [15:0] exp);
      logic [15:0] d;
      do_read(idx, d);
      check(tag, d, exp);
   endtask

   task automatic pulse_key(input logic pressed);
      @(negedge clk);
      key_evt = 1'b1; key_level = pressed;
      @(posedge clk);
      #1 key_evt = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      #3;
      check("R4 irq after reset", {15'd0, irq}, 16'd0);
      check("R8 shutdown after reset", {15'd0, shutdown_req}, 16'd0);
      check("R11 err after reset", {15'd0, acc_err}, 16'd0);

      for (int i = 0; i < NV; i++) begin
         logic [15:0] d;
         if (VEC[i][37])
            do_write(VEC[i][36:32], VEC[i][31:16]);
         else begin
            do_read(VEC[i][36:32], d);
            check($sformatf("R%0d vector %0d", VEC[i][41:38], i), d, VEC[i][15:0]);
         end
      end

      // R4: interrupt follows pending and mask
      do_write(5'h01, 16'h0008);
      check("R4 masked pending", {15'd0, irq}, 16'd0);
      do_write(5'h02, 16'hFFF7);
      check("R4 unmasked pending", {15'd0, irq}, 16'd1);
      read_check("R3 mask readback", 5'h02, 16'hFFF7);
      do_write(5'h02, 16'hFFFF);
      check("R4 remasked", {15'd0, irq}, 16'd0);
      do_write(5'h01, 16'h0008);
      read_check("R2 acknowledged", 5'h01, 16'h0000);

      // R1: variant bit
      variant_sel = 1'b1;
      read_check("R1 variant id", 5'h00, 16'h0295);
      variant_sel = 1'b0;

      // R7: power key
      pulse_key(1'b1);
      read_check("R7 status pressed", 5'h16, 16'h0000);
      read_check("R7 key pending", 5'h01, 16'h0001);
      pulse_key(1'b0);
      read_check("R7 status released", 5'h16, 16'h0020);
      do_write(5'h01, 16'h0001);
      read_check("R7 key acknowledged", 5'h01, 16'h0000);

      // R6: sample-control word
      @(negedge clk); adc_done = 1'b1;
      @(posedge clk); #1 adc_done = 1'b0;
      read_check("R6 done flag set", 5'h09, 16'h0001);
      do_write(5'h09, 16'h0000);
      read_check("R6 zero write no effect", 5'h09, 16'h0001);
      do_write(5'h09, 16'h0001);
      read_check("R6 one write clears", 5'h09, 16'h0000);

      // R11: unmapped holes
      check("R10 no error from unimplemented", {15'd0, acc_err}, 16'd0);
      read_check("R11 hole 7 reads zero", 5'h07, 16'h0000);
      check("R11 error set", {15'd0, acc_err}, 16'd1);
      read_check("R11 hole 0x12 reads zero", 5'h12, 16'h0000);
      read_check("R1 id after error", 5'h00, 16'h0215);
      check("R11 error sticky", {15'd0, acc_err}, 16'd1);

      // R8: watchdog shutdown (control bit is set)
      do_write(5'h17, 16'h0005);
      check("R8 nonzero write no shutdown", {15'd0, shutdown_req}, 16'd0);
      do_write(5'h17, 16'h0000);
      check("R8 shutdown pulse", {15'd0, shutdown_req}, 16'd1);
      @(posedge clk); #1;
      check("R8 pulse one cycle", {15'd0, shutdown_req}, 16'd0);
      do_write(5'h0D, 16'h0000);
      do_write(5'h17, 16'h0000);
      check("R8 disabled no shutdown", {15'd0, shutdown_req}, 16'd0);

      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule